// File: doc/BRIEF.md
# Index-Memory Transfer Sequencer

This block carries out the multi-byte memory operations of a small 8-bit interpreter CPU that has sixteen byte registers and a 12-bit index register. It works against a 4096-byte, byte-wide, single-port memory. It supports four operations:

- **Glyph pointer:** points the index at the built-in hex glyph for a register value.
- **Decimal store:** writes a register value as three decimal digits.
- **Spill:** stores the registers V0 through Vx into consecutive bytes.
- **Fill:** loads the registers V0 through Vx from consecutive bytes.

Spill and fill leave the index unchanged. Instruction fetch and arithmetic live elsewhere.

After reset the sequencer first writes the hex font into memory, and it reports busy while it does so. After that it waits for a command strobe. It performs at most one memory access per clock. It pulses done in the cycle after the last access of a command and returns to idle in the following cycle. Register values reach the block through a combinational read port. Register and index updates leave it through write strobes.

Top module: `idx_mem_xfer`

## Requirements
- R1: While reset is asserted, busy is 1, done is 0 and mem_en is 0. After reset the block writes 80 font bytes to addresses 0x050..0x09F and then goes idle without pulsing done. The byte for glyph g (0..15), row r (0..4) sits at 0x050+5g+r. Its upper nibble is a row pattern and its lower nibble is 0. The five row nibbles per glyph, in glyph order, are: F999F, 26227, F1F8F, F1F1F, 99F11, F8F1F, F8F9F, F1244, F9F9F, F9F1F, F9F99, E9E9E, F888F, E999E, F8F8F, F8F88.
- R2: A command is taken only when busy is 0 and cmd_valid is 1. cmd_op selects the operation: 0 = glyph pointer, 1 = decimal store, 2 = spill, 3 = fill. cmd_x names the register x. While idle, mem_en, rf_wr_en and idx_wr_en are all 0.
- R3: A glyph-pointer command makes no memory access. It pulses idx_wr_en with done, in the cycle after acceptance, carrying 0x050 + 5*Vx as a 12-bit value.
- R4: A decimal store writes Vx/100 to I, (Vx/10)%10 to I+1 and Vx%10 to I+2, one write per cycle. Each byte is 0..9. done follows the third write.
- R5: A spill writes V0..Vx to I..I+x, one write per cycle in ascending order. It makes x+1 writes and touches no other address.
- R6: A fill reads I..I+x, one read per cycle, with read data one cycle after the read. It writes the bytes to V0..Vx. Registers above Vx are not written.
- R7: Decimal store, spill and fill never pulse idx_wr_en, so the index stays unchanged.
- R8: Addresses used by commands are I+offset modulo 4096.
- R9: done is a single-cycle pulse, one cycle after the last access. Counted in clock edges after the accepting edge, it comes after 0, 3 and x+1 edges for glyph pointer, decimal store and spill/fill.
- R10: cmd_valid while busy, including during the font load, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command start strobe |
| cmd_op | input | 2 | Operation select |
| cmd_x | input | 4 | Register number x |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 8 | Register file read data (combinational) |
| idx_val | input | 12 | Current index register value |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 8 | Register write data |
| idx_wr_en | output | 1 | Index register write strobe |
| idx_wr_data | output | 12 | Index register write value |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 12 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read |
| busy | output | 1 | Font load or command in progress |
| done | output | 1 | Command completion pulse |

## Verification
A wrong offset counter shows up at the ports as a done pulse on the wrong edge. It also leaves a written byte out of place or a sentinel byte beside the range overwritten, and both are visible right after the command ends. A corrupted captured value shows as a wrong digit or glyph address in the same command. A load write-back that is off by one cycle places data into the wrong register, and the register check after done exposes it. A command that slips in while busy would change the index or the cycle count of the running command.

// File: rtl/idx_mem_xfer_pkg.sv
package idx_mem_xfer_pkg;

  localparam int GLYPH_ROWS = 5;

  typedef enum logic [1:0] {
    OP_GLYPH  = 2'd0,
    OP_DIGITS = 2'd1,
    OP_SPILL  = 2'd2,
    OP_FILL   = 2'd3
  } xfer_op_e;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_FONT,
    ST_IDLE,
    ST_DIGIT,
    ST_SPILL,
    ST_FILL,
    ST_FIN
  } xfer_st_e;

  // Row nibbles of one glyph, top row in the highest nibble.
  function automatic logic [4*GLYPH_ROWS-1:0] glyph_rows(input logic [3:0] g);
    case (g)
      4'h0: glyph_rows = 20'hF999F;
      4'h1: glyph_rows = 20'h26227;
      4'h2: glyph_rows = 20'hF1F8F;
      4'h3: glyph_rows = 20'hF1F1F;
      4'h4: glyph_rows = 20'h99F11;
      4'h5: glyph_rows = 20'hF8F1F;
      4'h6: glyph_rows = 20'hF8F9F;
      4'h7: glyph_rows = 20'hF1244;
      4'h8: glyph_rows = 20'hF9F9F;
      4'h9: glyph_rows = 20'hF9F1F;
      4'hA: glyph_rows = 20'hF9F99;
      4'hB: glyph_rows = 20'hE9E9E;
      4'hC: glyph_rows = 20'hF888F;
      4'hD: glyph_rows = 20'hE999E;
      4'hE: glyph_rows = 20'hF8F8F;
      default: glyph_rows = 20'hF8F88;
    endcase
  endfunction

endpackage

// File: rtl/xfer_glyph_rom.sv
module xfer_glyph_rom
  import idx_mem_xfer_pkg::*;
#(
  parameter int ROW_W = 3
) (
  input  logic [3:0]       glyph,
  input  logic [ROW_W-1:0] row,
  output logic [7:0]       row_byte
);

  logic [4*GLYPH_ROWS-1:0] pat;
  logic [3:0]              nib;

  always_comb begin
    pat = glyph_rows(glyph);
    nib = '0;
    for (int r = 0; r < GLYPH_ROWS; r++) begin
      if (row == ROW_W'(r)) nib = pat[4*(GLYPH_ROWS-1-r) +: 4];
    end
    row_byte = {nib, 4'h0};
  end

endmodule

// File: rtl/xfer_dec_split.sv
module xfer_dec_split (
  input  logic [7:0] val,
  output logic [3:0] hund,
  output logic [3:0] tens,
  output logic [3:0] ones
);

  logic [7:0] rem;

  always_comb begin
    if (val >= 8'd200) begin
      hund = 4'd2;
      rem  = val - 8'd200;
    end else if (val >= 8'd100) begin
      hund = 4'd1;
      rem  = val - 8'd100;
    end else begin
      hund = 4'd0;
      rem  = val;
    end
    // rem <= 99: multiply by 205 and shift by 11 is an exact divide by 10
    tens = 4'(({8'd0, rem} * 16'd205) >> 11);
    ones = 4'(rem - 8'(tens) * 8'd10);
  end

endmodule

// File: rtl/idx_mem_xfer.sv
module idx_mem_xfer
  import idx_mem_xfer_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          REG_CNT     = 16,
  parameter int          GLYPH_CNT   = 16,
  parameter int          GLYPH_BYTES = 5,
  parameter logic [11:0] FONT_BASE   = 12'h050
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(REG_CNT)-1:0] cmd_x,
  output logic [$clog2(REG_CNT)-1:0] rf_rd_idx,
  input  logic [7:0]                 rf_rd_data,
  input  logic [ADDR_W-1:0]          idx_val,
  output logic                       rf_wr_en,
  output logic [$clog2(REG_CNT)-1:0] rf_wr_idx,
  output logic [7:0]                 rf_wr_data,
  output logic                       idx_wr_en,
  output logic [ADDR_W-1:0]          idx_wr_data,
  output logic                       mem_en,
  output logic                       mem_we,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [7:0]                 mem_wdata,
  input  logic [7:0]                 mem_rdata,
  output logic                       busy,
  output logic                       done
);

  localparam int RIDX_W     = $clog2(REG_CNT);
  localparam int FONT_BYTES = GLYPH_CNT * GLYPH_BYTES;
  localparam int CNT_W      = $clog2(FONT_BYTES);
  localparam int GLY_W      = $clog2(GLYPH_CNT);
  localparam int ROW_W      = $clog2(GLYPH_BYTES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // state
  xfer_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [GLY_W-1:0]  gly_q, gly_d;
  logic [ROW_W-1:0]  row_q, row_d;
  xfer_op_e          op_q;
  logic [RIDX_W-1:0] last_q;
  logic [ADDR_W-1:0] base_q;
  logic [7:0]        val_q;
  logic              pend_q, pend_d;
  logic [RIDX_W-1:0] pend_idx_q, pend_idx_d;
  logic              cap_en;

  logic [7:0] font_byte;
  logic [3:0] d_hund, d_tens, d_ones;
  logic [3:0] digit;

  xfer_glyph_rom #(.ROW_W(ROW_W)) rom_i (
    .glyph    (4'(gly_q)),
    .row      (row_q),
    .row_byte (font_byte)
  );

  xfer_dec_split split_i (
    .val  (val_q),
    .hund (d_hund),
    .tens (d_tens),
    .ones (d_ones)
  );

  assign cap_en = (st_q == ST_IDLE) && cmd_valid;

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    gly_d = gly_q;
    row_d = row_q;
    case (st_q)
      ST_BOOT: begin
        st_d  = ST_FONT;
        cnt_d = '0;
        gly_d = '0;
        row_d = '0;
      end
      ST_FONT: begin
        if (cnt_q == CNT_W'(FONT_BYTES - 1)) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (row_q == ROW_W'(GLYPH_BYTES - 1)) begin
            row_d = '0;
            gly_d = gly_q + 1'b1;
          end else begin
            row_d = row_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        if (cmd_valid) begin
          cnt_d = '0;
          case (xfer_op_e'(cmd_op))
            OP_GLYPH:  st_d = ST_FIN;
            OP_DIGITS: st_d = ST_DIGIT;
            OP_SPILL:  st_d = ST_SPILL;
            default:   st_d = ST_FILL;
          endcase
        end
      end
      ST_DIGIT: begin
        if (cnt_q == CNT_W'(2)) st_d = ST_FIN;
        else                    cnt_d = cnt_q + 1'b1;
      end
      ST_SPILL, ST_FILL: begin
        if (cnt_q == CNT_W'(last_q)) st_d = ST_FIN;
        else                         cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign pend_d     = (st_q == ST_FILL);
  assign pend_idx_d = cnt_q[RIDX_W-1:0];

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q       <= ST_BOOT;
      cnt_q      <= '0;
      gly_q      <= '0;
      row_q      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      gly_q      <= gly_d;
      row_q      <= row_d;
      pend_q     <= pend_d;
      pend_idx_q <= pend_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q   <= OP_GLYPH;
      last_q <= '0;
      base_q <= '0;
      val_q  <= '0;
    end else if (cap_en) begin
      op_q   <= xfer_op_e'(cmd_op);
      last_q <= cmd_x;
      base_q <= idx_val;
      val_q  <= rf_rd_data;
    end
  end

  // outputs
  always_comb begin
    case (cnt_q[1:0])
      2'd0:    digit = d_hund;
      2'd1:    digit = d_tens;
      default: digit = d_ones;
    endcase
  end

  assign rf_rd_idx = (st_q == ST_SPILL) ? cnt_q[RIDX_W-1:0] : cmd_x;

  assign mem_en = (st_q == ST_FONT) || (st_q == ST_DIGIT) ||
                  (st_q == ST_SPILL) || (st_q == ST_FILL);
  assign mem_we = (st_q == ST_FONT) || (st_q == ST_DIGIT) || (st_q == ST_SPILL);

  always_comb begin
    if (st_q == ST_FONT) mem_addr = FONT_BASE + ADDR_W'(cnt_q);
    else                 mem_addr = base_q + ADDR_W'(cnt_q);
  end

  always_comb begin
    case (st_q)
      ST_FONT:  mem_wdata = font_byte;
      ST_DIGIT: mem_wdata = {4'h0, digit};
      ST_SPILL: mem_wdata = rf_rd_data;
      default:  mem_wdata = '0;
    endcase
  end

  assign rf_wr_en    = pend_q;
  assign rf_wr_idx   = pend_idx_q;
  assign rf_wr_data  = mem_rdata;

  assign idx_wr_en   = (st_q == ST_FIN) && (op_q == OP_GLYPH);
  assign idx_wr_data = FONT_BASE + ADDR_W'(GLYPH_BYTES) * ADDR_W'(val_q);

  assign done = (st_q == ST_FIN);
  assign busy = (st_q != ST_IDLE);

endmodule

// File: rtl/idx_mem_xfer_chk.sv
module idx_mem_xfer_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rf_wr_en,
  input logic              idx_wr_en,
  input logic [ADDR_W-1:0] idx_wr_data
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_en); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_en && !rf_wr_en && !idx_wr_en)); // R2

  AST_GLYPH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr_en |-> (done && idx_wr_data >= 12'h050 && idx_wr_data <= 12'h54B)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en) && (mem_we == $past(mem_we))) |->
      (mem_addr == $past(mem_addr) + 1'b1)); // R8

  AST_FILL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> $past(mem_en && !mem_we)); // R6

endmodule

bind idx_mem_xfer idx_mem_xfer_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .rf_wr_en    (rf_wr_en),
  .idx_wr_en   (idx_wr_en),
  .idx_wr_data (idx_wr_data)
);

// File: tb/idx_mem_xfer_tb_top.sv
module idx_mem_xfer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [3:0]  cmd_x;
  logic [3:0]  rf_rd_idx;
  logic [7:0]  rf_rd_data;
  logic [11:0] idx_val;
  logic        rf_wr_en;
  logic [3:0]  rf_wr_idx;
  logic [7:0]  rf_wr_data;
  logic        idx_wr_en;
  logic [11:0] idx_wr_data;
  logic        mem_en, mem_we;
  logic [11:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy, done;

  always #2.5 clk = ~clk;

  idx_mem_xfer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_x(cmd_x),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .idx_val(idx_val),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  // environment: memory, register file, index
  logic [7:0]  mem [4096];
  logic [7:0]  v [16];
  logic [11:0] ireg;
  int          done_cnt = 0;

  assign rf_rd_data = v[rf_rd_idx];
  assign idx_val    = ireg;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
    if (rf_wr_en)  v[rf_wr_idx] <= rf_wr_data;
    if (idx_wr_en) ireg <= idx_wr_data;
    if (done) done_cnt <= done_cnt + 1;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  localparam logic [39:0] FONT_EXP [16] = '{
    40'hF0909090F0, 40'h2060202070, 40'hF010F080F0, 40'hF010F010F0,
    40'h9090F01010, 40'hF080F010F0, 40'hF080F090F0, 40'hF010204040,
    40'hF090F090F0, 40'hF090F010F0, 40'hF090F09090, 40'hE090E090E0,
    40'hF0808080F0, 40'hE0909090E0, 40'hF080F080F0, 40'hF080F08080
  };

  // {op, x, val, I}
  localparam logic [25:0] VECS [12] = '{
    {2'd0, 4'd3,  8'h0A, 12'h000},
    {2'd0, 4'd0,  8'hFF, 12'h123},
    {2'd1, 4'd5,  8'd255, 12'h300},
    {2'd1, 4'd2,  8'd0,  12'h310},
    {2'd1, 4'd7,  8'd109, 12'hFFF},
    {2'd1, 4'd1,  8'd99, 12'h320},
    {2'd2, 4'd0,  8'h11, 12'h400},
    {2'd2, 4'd15, 8'h22, 12'h410},
    {2'd2, 4'd3,  8'h33, 12'hFFE},
    {2'd3, 4'd0,  8'h44, 12'h500},
    {2'd3, 4'd7,  8'h55, 12'h510},
    {2'd3, 4'd15, 8'h66, 12'hFFC}
  };

  task automatic run_cmd(input logic [1:0] op, input logic [3:0] x, output int lat);
    @(negedge clk);
    cmd_op = op; cmd_x = x; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat;
    int n;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_x = 4'd0;
    ireg = 12'h000;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h33;
    for (int i = 0; i < 16; i++) v[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy in reset", busy, 1);
    chk("R1", "done in reset", done, 0);
    chk("R1", "mem_en in reset", mem_en, 0);
    rst_n = 1'b1;
    // R10: strobe during font load ignored
    v[2] = 8'h07; ireg = 12'h777;
    cmd_op = 2'd0; cmd_x = 4'd2; cmd_valid = 1'b1;
    repeat (10) @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    chk("R1", "font load finished", busy, 0);
    chk("R1", "no done during font load", done_cnt, 0);
    chk("R10", "index kept during font load", ireg, 12'h777);
    for (int g = 0; g < 16; g++) begin
      int bad = 0;
      for (int r = 0; r < 5; r++)
        if (mem[12'h050 + 5*g + r] != FONT_EXP[g][39-8*r -: 8]) bad++;
      chk("R1", $sformatf("glyph %0d mismatching rows", g), bad, 0);
    end
    chk("R1", "byte below font untouched", mem[12'h04F], 8'h33);
    chk("R1", "byte above font untouched", mem[12'h0A0], 8'h33);

    // vector table
    for (int k = 0; k < 12; k++) begin
      logic [1:0]  op;
      logic [3:0]  x;
      logic [7:0]  val;
      logic [11:0] ib;
      {op, x, val, ib} = VECS[k];
      @(negedge clk);
      ireg = ib;
      for (int r = 0; r < 16; r++) v[r] = 8'h5A;
      if (op == 2'd2) for (int r = 0; r < 16; r++) v[r] = 8'(r*29 + 3) + val;
      v[x] = (op == 2'd2) ? v[x] : val;
      if (op == 2'd3) begin
        for (int r = 0; r <= x; r++) mem[12'(ib + r)] = 8'(r*13 + 8'hA1) ^ val;
        if (x != 4'd15) mem[12'(ib + x + 1)] = 8'hEE;
      end
      if (op == 2'd2) mem[12'(ib + x + 1)] = 8'hEE;
      if (op == 2'd1) mem[12'(ib + 3)] = 8'hEE;
      run_cmd(op, x, lat);
      case (op)
        2'd0: begin
          chk("R9", $sformatf("vec %0d glyph latency", k), lat, 0);
          chk("R3", $sformatf("vec %0d glyph index", k), ireg, 12'(12'h050 + 5*val));
        end
        2'd1: begin
          chk("R9", $sformatf("vec %0d digit latency", k), lat, 3);
          chk("R4", $sformatf("vec %0d hundreds", k), mem[ib], val / 100);
          chk("R4", $sformatf("vec %0d tens", k), mem[12'(ib + 1)], (val / 10) % 10);
          chk("R8", $sformatf("vec %0d ones (wrapped addr)", k), mem[12'(ib + 2)], val % 10);
          chk("R4", $sformatf("vec %0d byte after digits", k), mem[12'(ib + 3)], 8'hEE);
          chk("R7", $sformatf("vec %0d index kept", k), ireg, ib);
        end
        2'd2: begin
          int bad = 0;
          chk("R9", $sformatf("vec %0d spill latency", k), lat, x + 1);
          for (int r = 0; r <= x; r++)
            if (mem[12'(ib + r)] != 8'(8'(r*29 + 3) + val)) bad++;
          chk("R5", $sformatf("vec %0d spilled bytes wrong", k), bad, 0);
          chk("R5", $sformatf("vec %0d byte after spill", k), mem[12'(ib + x + 1)], 8'hEE);
          chk("R7", $sformatf("vec %0d index kept", k), ireg, ib);
        end
        default: begin
          int bad = 0;
          chk("R9", $sformatf("vec %0d fill latency", k), lat, x + 1);
          for (int r = 0; r <= x; r++)
            if (v[r] != (8'(r*13 + 8'hA1) ^ val)) bad++;
          chk("R6", $sformatf("vec %0d filled regs wrong", k), bad, 0);
          if (x != 4'd15) chk("R6", $sformatf("vec %0d reg above x", k), v[x + 1], 8'h5A);
          chk("R7", $sformatf("vec %0d index kept", k), ireg, ib);
        end
      endcase
    end

    // R10: strobes during a spill are ignored
    @(negedge clk);
    ireg = 12'h600;
    for (int r = 0; r < 16; r++) v[r] = 8'(r + 8'h80);
    cmd_op = 2'd2; cmd_x = 4'd15; cmd_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmd_op = 2'd0; cmd_x = 4'd1;
    n = 1;
    repeat (5) begin @(posedge clk); @(negedge clk); n++; end
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(posedge clk); @(negedge clk); lat++; end
    chk("R10", "spill latency with strobes while busy", lat + n - 1, 16);
    @(posedge clk); @(negedge clk);
    chk("R10", "index kept after busy strobes", ireg, 12'h600);
    chk("R5", "last spilled byte", mem[12'h60F], 8'h8F);
    chk("R9", "done low after pulse", done, 0);
    chk("R2", "idle after command", busy, 0);

    finish_run();
  end

endmodule